// File: doc/BRIEF.md
# Unordered Set-Associative Load Buffer

This block is a secondary load tracker that is switched on while a long-latency miss is outstanding. Each load that executes in the shadow of the miss has its cache-line address written into a small set-associative array. The set is chosen by the low bits of the line address, and each way keeps a valid bit and the remaining address bits as a tag. Outside a miss the primary load queue does this work, and this buffer ignores its inputs.

Every store that completes snoops the array. It reads the one set its own line address selects and compares the tags in that set. It never scans the whole structure. A match means a younger load may have read stale data. The block then raises a sticky violation flag and sends a one-cycle rollback request, so the pipeline restarts from its last checkpoint.

Load order is not recorded, and the block does not say which load was hit. When a load maps to a set whose ways are all occupied, the buffer cannot track that load. It flags a violation as a safe fallback. A checkpoint-clear input empties the array and drops the flag in a single cycle.

Top module: `unordered_load_buf`

## Requirements
- R1: After reset, `violation` and `rollbackReq` are low and no load line is recorded.
- R2: While `missActive` is low, load and store strobes are ignored. A load seen then is not recorded, so a later store to its line during a miss does not flag.
- R3: During a miss, a store whose line address (address bits 6 and up) equals a recorded load line sets `violation` on the next cycle. The byte offset within the line (bits 5:0) does not affect the match.
- R4: A store to a line that is not recorded does not flag. This includes a line that maps to the same set (bits 9:6) but has a different tag, and a line with the same tag bits but a different set.
- R5: When a load and a store arrive in the same cycle, the store is compared against the contents from before that load is inserted. The load is still recorded, so a later store to its line flags.
- R6: A load to a line already present takes no new way. With 4 ways, four distinct lines in one set are held without a flag, and a fifth distinct line to that set sets `violation`.
- R7: `violation` stays high until `ckptClear`. A clear empties every entry, so a store to a line recorded before the clear does not flag.
- R8: `rollbackReq` is high for exactly one cycle, the first cycle in which `violation` is high.
- R9: When `ckptClear` is asserted, a load or store in the same cycle is dropped. The load is not recorded and the store causes no flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| missActive | input | 1 | High while a long-latency miss is outstanding |
| ldValid | input | 1 | An executed load presents its address |
| ldAddr | input | ADDR_W | Load byte address |
| stValid | input | 1 | A completed store presents its address for snooping |
| stAddr | input | ADDR_W | Store byte address |
| ckptClear | input | 1 | Checkpoint taken or restored: empty the buffer and clear the flag |
| violation | output | 1 | Sticky memory-ordering violation |
| rollbackReq | output | 1 | One-cycle request to restart from the checkpoint |

## Verification
The snoop is tried with the exact recorded line, with another byte in that line, with a line in the same set under another tag, and with the same tag in another set. This separates true line matches from index-only or partial-tag matches. A load and a store to the same line in one cycle shows whether the snoop sees the contents from before the insert. Filling one set with repeated and then distinct lines shows the difference between deduplication and the capacity fallback. Clears issued together with a load and a store show that clear takes priority and that the buffer is really emptied. A reference model that keeps a plain list of recorded lines predicts every flag.

// File: rtl/lbuf_pkg.sv
package lbuf_pkg;
  typedef struct packed {
    logic clear;
    logic write;
  } lbufStrobe_t;
endpackage

// File: rtl/lbuf_array.sv
module lbuf_array #(
  parameter int ADDR_W = 32,
  parameter int LINE_W = 6,
  parameter int SETS   = 16,
  parameter int WAYS   = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  lbuf_pkg::lbufStrobe_t    strobe,
  input  logic [ADDR_W-1:0]        ldAddr,
  input  logic [ADDR_W-1:0]        stAddr,
  input  logic                     missActive,
  output logic                     snoopHit,
  output logic                     ldPresent,
  output logic                     setFull
);
  localparam int IDX_W = $clog2(SETS);
  localparam int TAG_W = ADDR_W - LINE_W - IDX_W;
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1;

  logic [SETS-1:0][WAYS-1:0] valid;
  logic [TAG_W-1:0]          tags [SETS][WAYS];

  logic [IDX_W-1:0] ldIdx, stIdx;
  logic [TAG_W-1:0] ldTag, stTag;
  logic [WAY_W-1:0] freeWay;

  assign ldIdx = ldAddr[LINE_W +: IDX_W];
  assign stIdx = stAddr[LINE_W +: IDX_W];
  assign ldTag = ldAddr[ADDR_W-1 -: TAG_W];
  assign stTag = stAddr[ADDR_W-1 -: TAG_W];

  always_comb begin
    snoopHit  = 1'b0;
    ldPresent = 1'b0;
    setFull   = 1'b1;
    freeWay   = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (valid[stIdx][w] && tags[stIdx][w] == stTag) snoopHit = 1'b1;
      if (valid[ldIdx][w] && tags[ldIdx][w] == ldTag) ldPresent = 1'b1;
      if (!valid[ldIdx][w]) begin
        setFull = 1'b0;
        freeWay = WAY_W'(w);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || strobe.clear) begin
      valid <= '0;
    end else if (strobe.write) begin
      valid[ldIdx][freeWay] <= 1'b1;
      tags[ldIdx][freeWay]  <= ldTag;
    end
  end

  // R7: a clear leaves no entry valid
  a_r7_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.clear |=> $countones(valid) == 0);
  // R2: outside a miss the array contents do not change
  a_r2_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!missActive && !strobe.clear) |=> $stable(valid));
  // R6: a write claims exactly one previously free way
  a_r6_write_one_way: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.write && !strobe.clear) |=> $countones(valid) == $past($countones(valid)) + 1);
endmodule

// File: rtl/lbuf_ctrl.sv
module lbuf_ctrl (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   missActive,
  input  logic                   ldValid,
  input  logic                   stValid,
  input  logic                   ckptClear,
  input  logic                   snoopHit,
  input  logic                   ldPresent,
  input  logic                   setFull,
  output lbuf_pkg::lbufStrobe_t  strobe,
  output logic                   violation,
  output logic                   rollbackReq
);
  logic doLoad, doSnoop, trigger;

  assign doLoad  = missActive && ldValid && !ckptClear;
  assign doSnoop = missActive && stValid && !ckptClear;
  assign trigger = (doSnoop && snoopHit) || (doLoad && !ldPresent && setFull);

  assign strobe.clear = ckptClear;
  assign strobe.write = doLoad && !ldPresent && !setFull;

  always_ff @(posedge clk) begin
    if (!rst_n || ckptClear) begin
      violation   <= 1'b0;
      rollbackReq <= 1'b0;
    end else begin
      violation   <= violation || trigger;
      rollbackReq <= trigger && !violation;
    end
  end

  // R7: the flag is sticky until a clear
  a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (violation && !ckptClear) |=> violation);
  // R9: a clear drops the flag whatever else arrives
  a_r9_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
    ckptClear |=> !violation && !rollbackReq);
  // R8: the request marks only the first flagged cycle
  a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rollbackReq |-> violation && !$past(violation));
  // R8: it lasts one cycle
  a_r8_pulse_ends: assert property (@(posedge clk) disable iff (!rst_n)
    rollbackReq |=> !rollbackReq);
endmodule

// File: rtl/unordered_load_buf.sv
module unordered_load_buf #(
  parameter int ADDR_W = 32,
  parameter int LINE_W = 6,
  parameter int SETS   = 16,
  parameter int WAYS   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              missActive,
  input  logic              ldValid,
  input  logic [ADDR_W-1:0] ldAddr,
  input  logic              stValid,
  input  logic [ADDR_W-1:0] stAddr,
  input  logic              ckptClear,
  output logic              violation,
  output logic              rollbackReq
);
  lbuf_pkg::lbufStrobe_t strobe;
  logic snoopHit, ldPresent, setFull;

  lbuf_ctrl i_ctrl (
    .clk(clk), .rst_n(rst_n), .missActive(missActive), .ldValid(ldValid),
    .stValid(stValid), .ckptClear(ckptClear), .snoopHit(snoopHit),
    .ldPresent(ldPresent), .setFull(setFull), .strobe(strobe),
    .violation(violation), .rollbackReq(rollbackReq)
  );

  lbuf_array #(.ADDR_W(ADDR_W), .LINE_W(LINE_W), .SETS(SETS), .WAYS(WAYS)) i_array (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .ldAddr(ldAddr), .stAddr(stAddr),
    .missActive(missActive), .snoopHit(snoopHit), .ldPresent(ldPresent),
    .setFull(setFull)
  );
endmodule

// File: tb/test_unordered_load_buf.sv
`timescale 1ns/1ps
module test_unordered_load_buf;
  localparam int ADDR_W = 32;
  localparam int LINE_W = 6;
  localparam int SETS   = 16;
  localparam int WAYS   = 4;
  localparam int IDX_W  = 4;
  localparam int LN_W   = ADDR_W - LINE_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic missActive = 1'b0, ldValid = 1'b0, stValid = 1'b0, ckptClear = 1'b0;
  logic [ADDR_W-1:0] ldAddr = '0, stAddr = '0;
  logic violation, rollbackReq;

  int nChecks = 0;
  int nFails  = 0;

  logic [LN_W-1:0] refLines [$];
  bit refViol = 1'b0;
  bit refPulse = 1'b0;

  always #2.5 clk = ~clk;

  unordered_load_buf #(.ADDR_W(ADDR_W), .LINE_W(LINE_W), .SETS(SETS), .WAYS(WAYS))
    i_unordered_load_buf (
      .clk(clk), .rst_n(rst_n), .missActive(missActive), .ldValid(ldValid),
      .ldAddr(ldAddr), .stValid(stValid), .stAddr(stAddr), .ckptClear(ckptClear),
      .violation(violation), .rollbackReq(rollbackReq));

  function automatic logic [ADDR_W-1:0] mk(int tag, int idx, int ofs);
    return {tag[LN_W-IDX_W-1:0], idx[IDX_W-1:0], ofs[LINE_W-1:0]};
  endfunction

  function automatic bit refHas(logic [LN_W-1:0] ln);
    foreach (refLines[i]) if (refLines[i] == ln) return 1'b1;
    return 1'b0;
  endfunction

  task automatic check(logic act, logic exp, string req);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  // Drive one cycle from a negedge; update the reference; check at the next negedge.
  task automatic step(bit ld, logic [ADDR_W-1:0] la, bit st, logic [ADDR_W-1:0] sa,
                      bit clr, bit miss, string req);
    bit trig, old;
    missActive = miss; ldValid = ld; ldAddr = la; stValid = st; stAddr = sa; ckptClear = clr;
    @(posedge clk);
    old = refViol;
    trig = 1'b0;
    if (clr) begin
      refLines.delete();
      refViol = 1'b0;
      refPulse = 1'b0;
    end else if (miss) begin
      if (st && refHas(sa[ADDR_W-1:LINE_W])) trig = 1'b1;
      if (ld && !refHas(la[ADDR_W-1:LINE_W])) begin
        int cnt = 0;
        foreach (refLines[i]) if (refLines[i][IDX_W-1:0] == la[LINE_W +: IDX_W]) cnt++;
        if (cnt >= WAYS) trig = 1'b1;
        else refLines.push_back(la[ADDR_W-1:LINE_W]);
      end
      refViol  = old || trig;
      refPulse = trig && !old;
    end else begin
      refPulse = 1'b0;
    end
    @(negedge clk);
    ldValid = 1'b0; stValid = 1'b0; ckptClear = 1'b0;
    check(violation, refViol, req);
    check(rollbackReq, refPulse, req);
  endtask

  task automatic t_reset();
    check(violation, 1'b0, "R1 violation after reset");
    check(rollbackReq, 1'b0, "R1 rollback after reset");
    step(0, '0, 1, mk(0, 0, 0), 0, 1, "R1 empty buffer snoop");
  endtask

  task automatic t_idle();
    step(1, mk(5, 3, 0), 0, '0, 0, 0, "R2 load outside miss");
    step(0, '0, 1, mk(5, 3, 8), 0, 1, "R2 store to unrecorded line");
    step(0, '0, 0, '0, 1, 1, "R2 clear");
  endtask

  task automatic t_hit();
    step(1, mk(9, 2, 4), 0, '0, 0, 1, "R3 record load");
    step(0, '0, 1, mk(9, 2, 60), 0, 1, "R3 R8 store other byte same line");
    step(0, '0, 0, '0, 0, 1, "R7 R8 sticky flag, pulse ended");
    step(0, '0, 0, '0, 0, 0, "R7 sticky outside miss");
    step(0, '0, 0, '0, 1, 1, "R7 clear");
  endtask

  task automatic t_miss();
    step(1, mk(7, 5, 0), 0, '0, 0, 1, "R4 record load");
    step(0, '0, 1, mk(8, 5, 0), 0, 1, "R4 same set other tag");
    step(0, '0, 1, mk(7, 6, 0), 0, 1, "R4 same tag other set");
    step(0, '0, 0, '0, 1, 1, "R4 clear");
  endtask

  task automatic t_same();
    step(1, mk(3, 1, 0), 1, mk(3, 1, 16), 0, 1, "R5 same-cycle load and store");
    step(0, '0, 1, mk(3, 1, 0), 0, 1, "R5 later store hits");
    step(0, '0, 0, '0, 1, 1, "R5 clear");
  endtask

  task automatic t_overflow();
    for (int i = 0; i < WAYS + 1; i++) step(1, mk(20, 9, i), 0, '0, 0, 1, "R6 repeated line");
    for (int t = 21; t < 20 + WAYS; t++) step(1, mk(t, 9, 0), 0, '0, 0, 1, "R6 fill set");
    step(1, mk(40, 9, 0), 0, '0, 0, 1, "R6 overflow flags");
    step(0, '0, 0, '0, 1, 1, "R6 clear");
  endtask

  task automatic t_clear();
    step(1, mk(11, 4, 0), 0, '0, 0, 1, "R7 record load");
    step(0, '0, 0, '0, 1, 1, "R7 clear");
    step(0, '0, 1, mk(11, 4, 0), 0, 1, "R7 store after clear");
    step(1, mk(12, 7, 0), 0, '0, 0, 1, "R9 record load");
    step(1, mk(13, 8, 0), 1, mk(12, 7, 0), 1, 1, "R9 clear beats load and store");
    step(0, '0, 1, mk(13, 8, 0), 0, 1, "R9 dropped load not recorded");
    step(0, '0, 1, mk(12, 7, 0), 0, 1, "R9 earlier load cleared");
  endtask

  initial begin
    #(200000 * 5);
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_idle();
    t_hit();
    t_miss();
    t_same();
    t_overflow();
    t_clear();
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule